// File: doc/BRIEF.md
# Configurable asynchronous serial transmitter

This block turns characters from a small internal holding queue into an asynchronous serial stream on one output line. The producer pushes characters into the queue. Whenever the queue holds a character and the start conditions are met, the transmitter sends a low start bit and the data bits, least significant first. Then, as configured, it sends a parity bit and one or two high stop bits. Word length, parity mode, stick parity, stop-bit count and break are plain control inputs. They are sampled when a character starts, and break is honoured only between characters.

Bit timing comes from an oversampling tick. Every bit lasts sixteen ticks. A tick period is the integer divisor in clock cycles, plus one extra cycle whenever a 6-bit fractional accumulator carries. The divisor is copied into the generator only while no character is in flight, so a change made mid-character applies from the next one. A new character also waits for the transmit enable, a legal divisor and, when flow control is on, a low clear-to-send input. A character that has started always runs to its end.

Top module: `uart_tx_core`

## Requirements
- R1: The line idles high. A character is one low start bit, then the data bits LSB first, then (if parity is on) one parity bit, then one high stop bit, or two when `two_stop_i`=1. The frame settings are sampled when the character starts.
- R2: `word_len_i` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Data bits above the selected length are not sent.
- R3: With `parity_en_i`=1 and `stick_sel_i`=0, the parity bit makes the count of ones in the data plus parity even when `even_sel_i`=1, and odd when `even_sel_i`=0.
- R4: With `parity_en_i`=1 and `stick_sel_i`=1, the parity bit is the constant `~even_sel_i`.
- R5: Each bit lasts 16 ticks. With integer divisor I and fraction F (in 64ths) latched at character start, bit k begins 16·k·I + floor(16·k·F/64) clock cycles after the start bit begins.
- R6: A divisor change during a character applies from the next character. No character starts while the divisor is illegal, meaning I=0, or I=0xFFFF with F≠0.
- R7: While `break_i`=1 the line is driven low, beginning only after the current character has completed. It returns high when `break_i` clears.
- R8: `tx_en_i` gates only the start of a character. Clearing it mid-character lets that character finish, and no further character starts.
- R9: With `cts_flow_en_i`=1 a character starts only while `cts_ni`=0. A started character is not interrupted when `cts_ni` rises.
- R10: `busy_o` is high whenever the queue is non-empty, even with transmit disabled, and stays high until the last stop bit has ended.
- R11: The queue holds DEPTH characters in FIFO order. `full_o` is high when it holds DEPTH characters, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push a character into the queue |
| push_data_i | input | 8 | Character to push |
| full_o | output | 1 | Queue full |
| tx_en_i | input | 1 | Transmit enable |
| word_len_i | input | 2 | Data bit count code |
| parity_en_i | input | 1 | Parity bit enable |
| even_sel_i | input | 1 | Even parity select |
| stick_sel_i | input | 1 | Stick parity select |
| two_stop_i | input | 1 | Two stop bits select |
| break_i | input | 1 | Send break |
| div_int_i | input | 16 | Integer divisor part |
| div_frac_i | input | 6 | Fractional divisor part in 64ths |
| cts_flow_en_i | input | 1 | Clear-to-send flow control enable |
| cts_ni | input | 1 | Active-low clear to send |
| txd_o | output | 1 | Serial output line |
| busy_o | output | 1 | Transmitter busy |

## Verification
The hardest situations to reach are those where a control input changes while a character is already on the line. Examples are a divisor rewrite, a transmit disable, a clear-to-send rise and a break request, each arriving partway through a frame. The stimulus pushes a character and then waits a fixed number of cycles so that the change lands mid-frame. It then checks that the frame just observed ran to completion, bit by bit at its old settings, before the new setting shows on the line. Fractional timing is checked by sampling every bit at an exactly predicted cycle, so a single misplaced extra cycle shifts a sample.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BREAK
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       even;
    logic       stick;
    logic       two_stop;
  } frame_cfg_t;

  function automatic logic calc_parity(logic [DATA_W-1:0] d, frame_cfg_t c);
    logic [DATA_W-1:0] m;
    m = d & (8'hFF >> (2'd3 - c.wlen));
    if (c.stick) return ~c.even;
    return c.even ? ^m : ~^m;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  output logic              tick_o,
  output logic              valid_o
);
  logic [INT_W-1:0]  cur_int, cnt, lim;
  logic [FRAC_W-1:0] cur_frac, acc;
  logic [FRAC_W:0]   sum;
  logic              last;

  assign sum     = {1'b0, acc} + {1'b0, cur_frac};
  // carry of the accumulator stretches this tick period by one cycle
  assign lim     = cur_int - INT_W'(1) + INT_W'(sum[FRAC_W]);
  assign last    = (cnt == lim);
  assign tick_o  = run_i && last;
  assign valid_o = (div_int_i != '0) && !((&div_int_i) && (div_frac_i != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_int  <= '0;
      cur_frac <= '0;
      cnt      <= '0;
      acc      <= '0;
    end else if (!run_i) begin
      cur_int  <= div_int_i;
      cur_frac <= div_frac_i;
      cnt      <= '0;
      acc      <= '0;
    end else if (last) begin
      cnt <= '0;
      acc <= sum[FRAC_W-1:0];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> ($stable(cur_int) && $stable(cur_frac))); // R6
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CW'(DEPTH)); // R11
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R11
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_ok_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] data_i,
  input  frame_cfg_t        cfg_i,
  input  logic              brk_i,
  output logic              pop_o,
  output logic              run_o,
  output logic              txd_o
);
  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        sub;
  logic [2:0]        bit_idx;
  logic              stop2, par_q;
  frame_cfg_t        cfg_q;

  assign pop_o = (state == S_IDLE) && !brk_i && !empty_i && start_ok_i;
  assign run_o = (state != S_IDLE) && (state != S_BREAK);

  always_comb begin
    unique case (state)
      S_START, S_BREAK: txd_o = 1'b0;
      S_DATA:           txd_o = shreg[0];
      S_PAR:            txd_o = par_q;
      default:          txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      shreg   <= '0;
      sub     <= '0;
      bit_idx <= '0;
      stop2   <= 1'b0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (brk_i) state <= S_BREAK;
          else if (pop_o) begin
            shreg <= data_i;
            cfg_q <= cfg_i;
            par_q <= calc_parity(data_i, cfg_i);
            sub   <= '0;
            state <= S_START;
          end
        end
        S_BREAK: if (!brk_i) state <= S_IDLE;
        default: if (tick_i) begin
          sub <= sub + 1'b1;
          if (&sub) begin
            case (state)
              S_START: begin
                state   <= S_DATA;
                bit_idx <= '0;
              end
              S_DATA: begin
                shreg <= {1'b0, shreg[DATA_W-1:1]};
                // last data index is word length code + 4
                if (bit_idx == {1'b1, cfg_q.wlen}) begin
                  state <= cfg_q.par_en ? S_PAR : S_STOP;
                  stop2 <= 1'b0;
                end else begin
                  bit_idx <= bit_idx + 1'b1;
                end
              end
              S_PAR: begin
                state <= S_STOP;
                stop2 <= 1'b0;
              end
              default: begin
                if (cfg_q.two_stop && !stop2) stop2 <= 1'b1;
                else state <= S_IDLE;
              end
            endcase
          end
        end
      endcase
    end
  end

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o) && !$past(tick_i)) |-> $stable(txd_o)); // R5
  AST_BREAK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_BREAK && $past(state) != S_BREAK) |-> ($past(state) == S_IDLE && $past(brk_i))); // R7
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              full_o,
  input  logic              tx_en_i,
  input  logic [1:0]        word_len_i,
  input  logic              parity_en_i,
  input  logic              even_sel_i,
  input  logic              stick_sel_i,
  input  logic              two_stop_i,
  input  logic              break_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              cts_flow_en_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              busy_o
);
  logic              q_empty, pop, run, tick, div_ok, start_ok;
  logic [DATA_W-1:0] q_data;
  frame_cfg_t        cfg;

  assign cfg      = '{wlen: word_len_i, par_en: parity_en_i, even: even_sel_i,
                      stick: stick_sel_i, two_stop: two_stop_i};
  assign start_ok = tx_en_i && div_ok && (!cts_flow_en_i || !cts_ni);
  assign busy_o   = !q_empty || run;

  uart_tx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i, .data_i(push_data_i), .pop_i(pop),
    .data_o(q_data), .empty_o(q_empty), .full_o
  );

  uart_baud_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i, .rst_ni, .run_i(run), .div_int_i, .div_frac_i,
    .tick_o(tick), .valid_o(div_ok)
  );

  uart_tx_shift u_shift (
    .clk_i, .rst_ni, .tick_i(tick), .start_ok_i(start_ok), .empty_i(q_empty),
    .data_i(q_data), .cfg_i(cfg), .brk_i(break_i), .pop_o(pop), .run_o(run), .txd_o
  );

  AST_CTS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> $past(!cts_flow_en_i || !cts_ni)); // R9
  AST_TXEN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> $past(tx_en_i)); // R8
  AST_DIV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> $past(div_ok)); // R6
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick)); // R10
endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 1'b0, tx_en = 1'b1, pen = 1'b0, even = 1'b0, stick = 1'b0, two = 1'b0;
  logic brk = 1'b0, cts_fe = 1'b0, cts_n = 1'b1;
  logic [7:0]  pdata = '0;
  logic [1:0]  wlen = 2'd3;
  logic [15:0] div_i = 16'd2;
  logic [5:0]  div_f = '0;
  logic full, txd, busy;

  always #4 clk = ~clk;

  uart_tx_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata), .full_o(full),
    .tx_en_i(tx_en), .word_len_i(wlen), .parity_en_i(pen), .even_sel_i(even),
    .stick_sel_i(stick), .two_stop_i(two), .break_i(brk), .div_int_i(div_i),
    .div_frac_i(div_f), .cts_flow_en_i(cts_fe), .cts_ni(cts_n), .txd_o(txd), .busy_o(busy)
  );

  typedef struct {
    logic [11:0] bits;
    int          n;
    int          ii;
    int          ff;
    string       tag;
  } frame_t;

  frame_t exp_q[$];
  int n_chk = 0, n_fail = 0, frames_done = 0;
  bit mon_en = 1'b1, finished = 1'b0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic frame_t make_frame(logic [7:0] d, string tag);
    frame_t f;
    int nb, idx;
    logic p;
    logic [7:0] m;
    nb = 5 + int'(wlen);
    f.bits = '0;
    f.bits[0] = 1'b0;
    m = '0;
    for (int i = 0; i < nb; i++) begin
      f.bits[1+i] = d[i];
      m[i] = d[i];
    end
    idx = 1 + nb;
    if (pen) begin
      p = stick ? ~even : (even ? ^m : ~^m);
      f.bits[idx] = p;
      idx++;
    end
    f.bits[idx] = 1'b1; idx++;
    if (two) begin f.bits[idx] = 1'b1; idx++; end
    f.n = idx;
    f.ii = int'(div_i);
    f.ff = int'(div_f);
    f.tag = tag;
    return f;
  endfunction

  task automatic push_raw(logic [7:0] d);
    @(negedge clk);
    push = 1'b1; pdata = d;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic send(logic [7:0] d, string tag);
    exp_q.push_back(make_frame(d, tag));
    push_raw(d);
  endtask

  task automatic wait_frames(int target);
    while (frames_done < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // monitor: bit k of a frame sampled mid-bit at the cycle predicted by R5
  initial begin
    logic last = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && last && !txd) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected frame", 1, 0);
        end else begin
          frame_t f;
          longint el, tgt;
          f = exp_q.pop_front();
          el = 0;
          for (int k = 0; k < f.n; k++) begin
            tgt = 64'(16 * k * f.ii) + 64'((16 * k * f.ff) / 64) + 64'(8 * f.ii);
            repeat (int'(tgt - el)) @(negedge clk);
            el = tgt;
            check(txd == f.bits[k], $sformatf("%s bit%0d", f.tag, k), txd, f.bits[k]);
          end
          frames_done++;
        end
      end
      last = txd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0 && full == 1'b0, "R1 R10 R11 reset", {txd, busy, full}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: 8N1
    base = frames_done;
    send(8'hA5, "R1 8n1 a5");
    send(8'h3C, "R1 8n1 3c");
    wait_frames(base + 2);
    check(busy == 1'b1, "R10 busy during last stop", busy, 1);
    wait_idle();
    check(busy == 1'b0, "R10 idle after stop", busy, 0);

    // R2 R3: 5 bits even, 7 bits odd two stops
    wlen = 2'd0; pen = 1'b1; even = 1'b1;
    send(8'h13, "R2 R3 5e1");
    send(8'hFF, "R2 R3 5e1 ff");
    wait_idle();
    wlen = 2'd2; even = 1'b0; two = 1'b1;
    send(8'h55, "R1 R3 7o2");
    wait_idle();
    two = 1'b0;

    // R4: stick parity
    wlen = 2'd1; stick = 1'b1; even = 1'b0;
    send(8'h00, "R4 stick one");
    wait_idle();
    even = 1'b1;
    send(8'h3F, "R4 stick zero");
    wait_idle();
    stick = 1'b0; pen = 1'b0; even = 1'b0; wlen = 2'd3;

    // R5: fractional divisor
    div_i = 16'd3; div_f = 6'd20;
    send(8'h96, "R5 frac 96");
    send(8'h69, "R5 frac 69");
    wait_idle();
    div_i = 16'd2; div_f = 6'd0;

    // R6: divisor change mid character
    send(8'hC3, "R6 old div");
    repeat (40) @(negedge clk);
    div_i = 16'd4;
    send(8'h3C, "R6 new div");
    wait_idle();
    div_i = 16'd2;

    // R6: illegal divisors hold start
    div_i = 16'd0;
    send(8'h81, "R6 after illegal");
    repeat (300) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b1, "R6 R10 zero div holds", {txd, busy}, 2'b11);
    div_i = 16'hFFFF; div_f = 6'd1;
    repeat (100) @(negedge clk);
    check(txd == 1'b1, "R6 ffff+frac holds", txd, 1);
    div_i = 16'd2; div_f = 6'd0;
    exp_q[0].ii = 2; exp_q[0].ff = 0;
    wait_idle();

    // R8: enable gating
    tx_en = 1'b0;
    send(8'h42, "R8 after enable");
    repeat (300) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b1, "R8 R10 disabled holds", {txd, busy}, 2'b11);
    tx_en = 1'b1;
    wait_idle();
    base = frames_done;
    send(8'h11, "R8 completes");
    send(8'h22, "R8 resumed");
    repeat (50) @(negedge clk);
    tx_en = 1'b0;
    wait_frames(base + 1);
    repeat (600) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b1 && exp_q.size() == 1, "R8 no next start",
          {txd, busy, 1'(exp_q.size())}, 3'b111);
    tx_en = 1'b1;
    wait_idle();

    // R9: clear to send
    cts_fe = 1'b1; cts_n = 1'b1;
    base = frames_done;
    send(8'h5A, "R9 cts frame");
    repeat (300) @(negedge clk);
    check(txd == 1'b1, "R9 held by cts", txd, 1);
    cts_n = 1'b0;
    repeat (50) @(negedge clk);
    cts_n = 1'b1;
    wait_frames(base + 1);
    check(frames_done == base + 1, "R9 not interrupted", frames_done, base + 1);
    wait_idle();
    cts_fe = 1'b0;

    // R11: full queue, dropped push, order
    tx_en = 1'b0;
    send(8'h01, "R11 q0");
    send(8'h02, "R11 q1");
    send(8'h03, "R11 q2");
    send(8'h04, "R11 q3");
    check(full == 1'b1, "R11 full", full, 1);
    push_raw(8'hEE);
    tx_en = 1'b1;
    wait_idle();
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0 && busy == 1'b0 && txd == 1'b1, "R11 dropped push",
          {1'(exp_q.size()), busy, txd}, 3'b001);

    // R7: break after current character
    base = frames_done;
    send(8'hF0, "R7 before break");
    repeat (40) @(negedge clk);
    brk = 1'b1;
    wait_frames(base + 1);
    mon_en = 1'b0;
    check(txd == 1'b1, "R7 stop not cut", txd, 1);
    repeat (100) @(negedge clk);
    check(txd == 1'b0, "R7 break low", txd, 0);
    repeat (300) @(negedge clk);
    check(txd == 1'b0, "R7 break held", txd, 0);
    brk = 1'b0;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R7 break released", txd, 1);
    repeat (5) @(negedge clk);
    mon_en = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule